// File: doc/BRIEF.md
# Write Protection and Status Unit

This block sits beside the serial command engine of a small serial EEPROM. It holds the status byte, makes every allow-or-refuse decision for writes, and times the self-timed program cycle. The command engine sends it one-cycle pulses: arm writes, disarm writes, load the status byte, and start an array program with a start address and byte count. It returns the status byte for status reads, a per-address write-allowed flag, a busy flag, and a one-cycle commit strobe that tells the array to take in its buffered data once the program time has run out.

A write goes ahead only when three things all hold: the protect pin is high, the one-shot arm latch is set, and the target address is outside the range that the two lock bits select. The arm latch clears itself at the end of every program cycle, so each write must be armed again. The program time is a parameterised count of clock cycles.

The controller has three states. `ST_IDLE` takes commands. `ST_PROG_ARRAY` times an array program. `ST_PROG_STATUS` times a status-byte program. There are four transitions. IDLE goes to PROG_ARRAY on an accepted array start, and to PROG_STATUS on an accepted status load. Each PROG state goes back to IDLE on its last timed cycle. When an array program ends, `commit_o` pulses. When a status program ends, the lock bits are updated.

Top module: `wps_unit`

## Requirements
- R1: `status_o` is laid out as follows. Bits 3..2 are the lock bits. Bit 1 is the arm latch. Bit 0 is busy, where 1 means a program cycle is running. Bits 7..4 always read 0. After reset the whole byte is 0x00.
- R2: The arm latch is 0 after reset. An `arm_set_i` pulse sets it, and an `arm_clr_i` pulse clears it.
- R3: The lock code selects the protected range for the default 9-bit address. Code 00 protects no address. Code 01 protects 0x180–0x1FF. Code 10 protects 0x100–0x1FF. Code 11 protects 0x000–0x1FF.
- R4: `probe_ok_o` is 1 only when `prot_pin_n_i` is 1, the arm latch is 1, and `probe_addr_i` is outside the protected range. It follows its inputs within the same cycle.
- R5: An `arr_start_i` pulse is accepted only when all of these hold: the unit is idle, `arr_count_i` is nonzero, the pin is high, the unit is armed, and `arr_addr_i` is unprotected. An accepted pulse makes `busy_o` high for exactly PROG_CYCLES cycles, starting the cycle after the pulse. `commit_o` then pulses for one cycle, in the cycle after busy falls. A refused pulse changes no output.
- R6: A `sr_load_i` pulse is accepted only when the unit is idle, the pin is high and the unit is armed. An accepted pulse runs a busy period of PROG_CYCLES cycles. At its end the lock bits take `sr_data_i[3:2]`, and the other data bits are ignored. No commit pulse follows. A refused pulse changes nothing.
- R7: The arm latch reads 0 after any program cycle ends.
- R8: If the pin falls during a program cycle, that cycle still runs its full length, and an array program still commits.
- R9: While busy, the unit ignores every command pulse. The arm latch, the lock bits and the busy length stay as they were.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| prot_pin_n_i | input | 1 | Protect pin; 0 blocks all writes |
| arm_set_i | input | 1 | Pulse: set arm latch |
| arm_clr_i | input | 1 | Pulse: clear arm latch |
| sr_load_i | input | 1 | Pulse: program status byte |
| sr_data_i | input | 8 | Status byte data; only bits 3..2 are used |
| arr_start_i | input | 1 | Pulse: start array program |
| arr_addr_i | input | ADDR_W | Start address of the array program |
| arr_count_i | input | CNT_W | Number of buffered bytes |
| probe_addr_i | input | ADDR_W | Address to test for write permission |
| probe_ok_o | output | 1 | Write allowed at probe address |
| status_o | output | 8 | Status byte |
| busy_o | output | 1 | Program cycle running |
| commit_o | output | 1 | One-cycle strobe that applies buffered data to the array |

## Verification
The bench goes after the edges of the protected ranges: 0x17F against 0x180, and 0x0FF against 0x100. A decoder that is off by one bit slice would allow or refuse the wrong neighbour there. During a busy period the bench sends disarm and status-load pulses and drops the pin. A design that obeys those commands would change the arm bit or the lock bits in mid-cycle, or cut the cycle short and lose the commit. The bench counts the exact busy length and the number of commit pulses, which catches off-by-one timers and repeated strobes. It also tries refused starts (disarmed, protected address, zero bytes, pin low). A design that leaks any of these would show a busy period that should not be there.

// File: rtl/wps_pkg.sv
package wps_pkg;
    typedef enum logic [1:0] {
        ST_IDLE        = 2'd0,
        ST_PROG_ARRAY  = 2'd1,
        ST_PROG_STATUS = 2'd2
    } wps_state_e;

    localparam int LOCK_W = 2;
endpackage

// File: rtl/wps_range_guard.sv
module wps_range_guard #(
    parameter int ADDR_W = 9
) (
    input  logic [1:0]        lock_i,
    input  logic [ADDR_W-1:0] addr_i,
    output logic              locked_o
);
    localparam int TOP = ADDR_W - 1;

    // Code 01 locks the top quarter, code 10 the top half, code 11 everything.
    always_comb begin
        unique case (lock_i)
            2'b00:   locked_o = 1'b0;
            2'b01:   locked_o = addr_i[TOP] & addr_i[TOP-1];
            2'b10:   locked_o = addr_i[TOP];
            default: locked_o = 1'b1;
        endcase
    end
endmodule

// File: rtl/wps_prog_timer.sv
module wps_prog_timer #(
    parameter int PROG_CYCLES = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    output logic running_o,
    output logic last_o
);
    localparam int CW = $clog2(PROG_CYCLES + 1);
    localparam logic [CW-1:0] LOAD = CW'(PROG_CYCLES - 1);

    logic [CW-1:0] cnt_q;
    logic          run_q;

    assign running_o = run_q;
    assign last_o    = run_q && (cnt_q == '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            run_q <= 1'b0;
        end else if (start_i && !run_q) begin
            cnt_q <= LOAD;
            run_q <= 1'b1;
        end else if (run_q) begin
            if (cnt_q == '0) run_q <= 1'b0;
            else             cnt_q <= cnt_q - 1'b1;
        end
    end
endmodule

// File: rtl/wps_unit.sv
module wps_unit
    import wps_pkg::*;
#(
    parameter int ADDR_W      = 9,
    parameter int PAGE_BYTES  = 4,
    parameter int PROG_CYCLES = 1000,
    localparam int CNT_W      = $clog2(PAGE_BYTES + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              prot_pin_n_i,
    input  logic              arm_set_i,
    input  logic              arm_clr_i,
    input  logic              sr_load_i,
    input  logic [7:0]        sr_data_i,
    input  logic              arr_start_i,
    input  logic [ADDR_W-1:0] arr_addr_i,
    input  logic [CNT_W-1:0]  arr_count_i,
    input  logic [ADDR_W-1:0] probe_addr_i,
    output logic              probe_ok_o,
    output logic [7:0]        status_o,
    output logic              busy_o,
    output logic              commit_o
);
    wps_state_e        state_q, state_d;
    logic              arm_q;
    logic [LOCK_W-1:0] lock_q, lock_pend_q;
    logic              commit_q;
    logic              probe_locked, start_locked;
    logic              tmr_running, tmr_last;
    logic              idle, write_gate, take_arr, take_sr;

    wps_range_guard #(.ADDR_W(ADDR_W)) u_probe_guard (
        .lock_i(lock_q), .addr_i(probe_addr_i), .locked_o(probe_locked));

    wps_range_guard #(.ADDR_W(ADDR_W)) u_start_guard (
        .lock_i(lock_q), .addr_i(arr_addr_i), .locked_o(start_locked));

    wps_prog_timer #(.PROG_CYCLES(PROG_CYCLES)) u_timer (
        .clk(clk), .rst_n(rst_n), .start_i(take_arr | take_sr),
        .running_o(tmr_running), .last_o(tmr_last));

    assign idle       = (state_q == ST_IDLE);
    assign write_gate = prot_pin_n_i & arm_q;
    assign take_arr   = idle & arr_start_i & (arr_count_i != '0)
                        & write_gate & ~start_locked;
    assign take_sr    = idle & ~arr_start_i & sr_load_i & write_gate;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (take_arr)     state_d = ST_PROG_ARRAY;
                else if (take_sr) state_d = ST_PROG_STATUS;
            end
            ST_PROG_ARRAY:  if (tmr_last) state_d = ST_IDLE;
            ST_PROG_STATUS: if (tmr_last) state_d = ST_IDLE;
            default:        state_d = ST_IDLE;
        endcase
    end

    // data registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            arm_q       <= 1'b0;
            lock_q      <= '0;
            lock_pend_q <= '0;
            commit_q    <= 1'b0;
        end else begin
            commit_q <= (state_q == ST_PROG_ARRAY) && tmr_last;
            if (idle) begin
                if (take_sr)
                    lock_pend_q <= sr_data_i[3:2];
                else if (!arr_start_i && !sr_load_i) begin
                    if (arm_set_i)      arm_q <= 1'b1;
                    else if (arm_clr_i) arm_q <= 1'b0;
                end
            end else if (tmr_last) begin
                arm_q <= 1'b0;
                if (state_q == ST_PROG_STATUS) lock_q <= lock_pend_q;
            end
        end
    end

    // outputs
    always_comb begin
        busy_o     = !idle;
        commit_o   = commit_q;
        probe_ok_o = write_gate & ~probe_locked;
        status_o   = {4'b0000, lock_q, arm_q, !idle};
    end

    // R5
    busy_timer_agree_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o == tmr_running);
    // R5
    commit_after_array_chk: assert property (@(posedge clk) disable iff (!rst_n)
        commit_o |-> ($past(state_q) == ST_PROG_ARRAY) && !busy_o);
    // R5
    commit_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        commit_o |=> !commit_o);
    // R4
    start_permitted_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> $past(prot_pin_n_i && arm_q));
    // R7
    arm_cleared_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> !arm_q);
    // R9
    lock_frozen_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !tmr_last) |=> $stable(lock_q));
    // R8
    busy_runs_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !tmr_last) |=> busy_o);
endmodule

// File: tb/wps_unit_tb.sv
module wps_unit_tb_top;
    localparam int ADDR_W = 9;
    localparam int PAGE   = 4;
    localparam int PROG   = 12;
    localparam int CNT_W  = $clog2(PAGE + 1);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic prot_pin_n = 1'b1, arm_set = 1'b0, arm_clr = 1'b0, sr_load = 1'b0, arr_start = 1'b0;
    logic [7:0] sr_data = '0;
    logic [ADDR_W-1:0] arr_addr = '0, probe_addr = '0;
    logic [CNT_W-1:0] arr_count = '0;
    logic probe_ok, busy, commit;
    logic [7:0] status;

    int tests = 0, fails = 0;
    int busy_seen = 0, commits_seen = 0;
    bit done = 0;

    always #5 clk = ~clk;

    wps_unit #(.ADDR_W(ADDR_W), .PAGE_BYTES(PAGE), .PROG_CYCLES(PROG)) dut_i (
        .clk(clk), .rst_n(rst_n), .prot_pin_n_i(prot_pin_n),
        .arm_set_i(arm_set), .arm_clr_i(arm_clr),
        .sr_load_i(sr_load), .sr_data_i(sr_data),
        .arr_start_i(arr_start), .arr_addr_i(arr_addr), .arr_count_i(arr_count),
        .probe_addr_i(probe_addr), .probe_ok_o(probe_ok),
        .status_o(status), .busy_o(busy), .commit_o(commit));

    // behavioural reference model
    int m_arm = 0, m_lock = 0, m_pend = 0, m_left = 0, m_commit = 0, m_kind = 0;

    function automatic bit in_locked(int lock, int a);
        case (lock)
            1: return a >= 'h180;
            2: return a >= 'h100;
            3: return 1;
            default: return 0;
        endcase
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_arm = 0; m_lock = 0; m_pend = 0; m_left = 0; m_commit = 0;
        end else if (m_left > 0) begin
            m_commit = 0;
            m_left--;
            if (m_left == 0) begin
                m_arm = 0;
                if (m_kind == 1) m_commit = 1; else m_lock = m_pend;
            end
        end else begin
            m_commit = 0;
            if (arr_start) begin
                if (arr_count != 0 && prot_pin_n && m_arm == 1 && !in_locked(m_lock, arr_addr)) begin
                    m_left = PROG; m_kind = 1;
                end
            end else if (sr_load) begin
                if (prot_pin_n && m_arm == 1) begin
                    m_left = PROG; m_kind = 0; m_pend = sr_data[3:2];
                end
            end else if (arm_set) m_arm = 1;
            else if (arm_clr) m_arm = 0;
        end
    end

    task automatic check(string tag, int act, int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // per-cycle comparison, sampled 2 ns after the edge
    always @(posedge clk) begin
        #2;
        if (rst_n) begin
            check("R1 status", status, (m_lock << 2) | (m_arm << 1) | (m_left > 0 ? 1 : 0));
            check("R5 busy", busy, m_left > 0 ? 1 : 0);
            check("R5 commit", commit, m_commit);
            check("R4 probe", probe_ok,
                  (prot_pin_n && m_arm == 1 && !in_locked(m_lock, probe_addr)) ? 1 : 0);
            if (busy) busy_seen++;
            if (commit) commits_seen++;
        end
    end

    // kind: 0 arm set, 1 arm clear, 2 status load, 3 array start
    task automatic cmd(int kind, int data = 0, int addr = 0, int cnt = 1);
        @(negedge clk);
        sr_data = 8'(data); arr_addr = ADDR_W'(addr); arr_count = CNT_W'(cnt);
        case (kind)
            0: arm_set = 1'b1;
            1: arm_clr = 1'b1;
            2: sr_load = 1'b1;
            default: arr_start = 1'b1;
        endcase
        @(negedge clk);
        arm_set = 1'b0; arm_clr = 1'b0; sr_load = 1'b0; arr_start = 1'b0;
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 4 * PROG && busy; i++) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic probe(int a, int exp, string tag);
        probe_addr = ADDR_W'(a);
        #1;
        check(tag, probe_ok, exp);
    endtask

    task automatic set_lock(int code);
        cmd(0);
        cmd(2, code << 2);
        wait_idle();
        cmd(0);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    endtask

    initial begin
        #(10 * 200000);
        fails++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 reset status", status, 8'h00);

        cmd(0); check("R2 arm set", status[1], 1);
        cmd(1); check("R2 arm clear", status[1], 0);

        cmd(3, 0, 'h020, 1); check("R5 refused when disarmed", busy, 0);

        cmd(0); cmd(2, 'hF6);
        check("R6 status load starts busy", busy, 1);
        wait_idle();
        check("R6 only bits 3..2 taken", status, 8'h04);
        check("R7 arm cleared after program", status[1], 0);

        cmd(0);
        probe('h17F, 1, "R3 code01 below edge");
        probe('h180, 0, "R3 code01 at edge");
        cmd(3, 0, 'h1A0, 2); check("R5 refused in locked range", busy, 0);

        busy_seen = 0; commits_seen = 0;
        cmd(3, 0, 'h010, 4);
        check("R5 array start accepted", busy, 1);
        cmd(1);
        cmd(2, 'h0C);
        cmd(0);
        prot_pin_n = 1'b0;
        wait_idle();
        check("R5 busy length", busy_seen, PROG);
        check("R8 one commit despite pin drop", commits_seen, 1);
        check("R9 lock unchanged by load while busy", status[3:2], 1);
        check("R7 arm cleared after array program", status[1], 0);

        cmd(0);
        probe('h000, 0, "R4 pin low blocks");
        cmd(2, 'h00); check("R6 refused with pin low", busy, 0);
        prot_pin_n = 1'b1;
        probe('h000, 1, "R4 pin high allows");

        cmd(3, 0, 'h000, 0); check("R5 zero count refused", busy, 0);

        set_lock(2);
        probe('h0FF, 1, "R3 code10 below edge");
        probe('h100, 0, "R3 code10 at edge");
        set_lock(3);
        probe('h000, 0, "R3 code11 bottom");
        set_lock(0);
        probe('h1FF, 1, "R3 code00 top");
        check("R1 final status", status, 8'h02);

        repeat (3) @(negedge clk);
        finish_run();
    end
endmodule